// File: doc/BRIEF.md
# Bitonic Sorting Network for Sixteen Values

This block puts sixteen unsigned values into ascending order. The input is one flat vector of sixteen lanes. Lane `i` occupies bits `[i*W +: W]`. The sorted result leaves on a vector with the same layout, and lane 0 holds the smallest value. The network has a fixed shape. It has ten stages of eight compare-and-swap cells, 80 cells in all. In each cell, a magnitude comparator drives the select of two 2-to-1 multiplexers. Those multiplexers send the two values to the cell's lower and upper outputs. The order of the cells never depends on the data.

The stages follow the bitonic merge order. There are four phases, with block sizes 2, 4, 8 and 16. Inside each phase the comparison distance halves from stage to stage. In the first three phases, a cell's direction is ascending when bit `log2(block)` of its lower lane index is clear, and descending otherwise. This produces bitonic sequences for the next phase. The last phase is ascending throughout.

The parameter `PIPE` selects the timing. With `PIPE=1`, a register bank follows every stage, so a new vector can enter on every cycle and its result appears ten cycles later. With `PIPE=0`, the network is purely combinational.

Top module: `bitonic_sorter`

## Requirements
- R1: On every cycle, the `dout` lanes are non-decreasing from lane 0 to lane 15. Lane `i` sits at bits `[i*W +: W]`.
- R2: The lanes of `dout` form the same multiset as the lanes of the input vector that produced them. Equal values may be routed either way.
- R3: With `PIPE=1`, the result for a vector driven on `din` before a rising edge appears on `dout` after exactly ten rising edges. A new vector is accepted on every cycle.
- R4: With `PIPE=0`, `dout` is a combinational function of `din` and shows the sorted result in the same cycle.
- R5: With `PIPE=1`, while `rst_n` is low every stage register is cleared, so `dout` reads all zeros.
- R6: An input that is already ascending leaves the block unchanged. An input that is strictly descending comes out fully reversed.
- R7: An input whose sixteen lanes all hold the same value comes out with all sixteen lanes equal to that value.
- R8: The minimum value 0 and the all-ones value `2**W-1` sort correctly. The all-ones value lands in lane 15 whenever it is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the stage registers and the checks |
| rst_n | input | 1 | Asynchronous active-low reset of the stage registers |
| din | input | 16*W | Sixteen unsigned lanes to be sorted; lane i at bits [i*W +: W] |
| dout | output | 16*W | Sorted lanes, smallest in lane 0 |

## Verification
The assertions assume that `din` carries known values on every clock edge after reset. The ordering and sum checks have no meaning for unknown bits. The bench therefore drives a full vector from time zero and holds reset across the first edges. The stimulus uses 4-bit lanes so that duplicates are frequent. Roughly half the random vectors draw from only four values. The directed vectors cover sorted, reversed, constant and extreme-valued inputs. The expected order is computed from a value histogram. Both a pipelined instance and a combinational instance are compared against it.

// File: rtl/bitonic_sorter.sv
module bitonic_sorter #(
  parameter int W    = 8,
  parameter bit PIPE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [16*W-1:0] din,
  output logic [16*W-1:0] dout
);
  localparam int N      = 16;
  localparam int LG     = $clog2(N);
  localparam int STAGES = LG * (LG + 1) / 2;
  localparam int SW     = W + LG;

  function automatic int blk_of(input int s);
    int t, r;
    t = s;
    r = 0;
    for (int p = 1; p <= LG; p++) begin
      if (r == 0 && t < p) r = 1 << p;
      if (r == 0) t = t - p;
    end
    return r;
  endfunction

  function automatic int dist_of(input int s);
    int t, r;
    t = s;
    r = 0;
    for (int p = 1; p <= LG; p++) begin
      if (r == 0 && t < p) r = 1 << (p - 1 - t);
      if (r == 0) t = t - p;
    end
    return r;
  endfunction

  function automatic logic [SW-1:0] vsum(input logic [N*W-1:0] v);
    logic [SW-1:0] acc;
    acc = '0;
    for (int k = 0; k < N; k++) acc = acc + SW'(v[k*W +: W]);
    return acc;
  endfunction

  logic [STAGES:0][N*W-1:0]   sv;
  logic [STAGES-1:0][N*W-1:0] nx;

  assign sv[0] = din;
  assign dout  = sv[STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int K = blk_of(s);
    localparam int J = dist_of(s);
    for (genvar i = 0; i < N; i++) begin : g_lane
      if ((i & J) == 0) begin : g_cell
        localparam bit ASC = ((i & K) == 0);
        logic [W-1:0] a, b;
        logic         sel;
        assign a   = sv[s][i*W +: W];
        assign b   = sv[s][(i+J)*W +: W];
        assign sel = ASC ? (a > b) : (b > a);
        assign nx[s][i*W +: W]     = sel ? b : a;
        assign nx[s][(i+J)*W +: W] = sel ? a : b;
      end
    end

    AST_STAGE_SUM: assert property (@(posedge clk) disable iff (!rst_n) vsum(nx[s]) == vsum(sv[s])); // R2
  end

  if (PIPE) begin : g_pipe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 1; s <= STAGES; s++) sv[s] <= '0;
      end else begin
        for (int s = 1; s <= STAGES; s++) sv[s] <= nx[s-1];
      end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> dout == '0); // R5
  end else begin : g_comb
    for (genvar s = 1; s <= STAGES; s++) begin : g_wire
      assign sv[s] = nx[s-1];
    end

    for (genvar i = 0; i < N; i++) begin : g_max
      AST_TOP_IS_MAX: assert property (@(posedge clk) disable iff (!rst_n) dout[(N-1)*W +: W] >= din[i*W +: W]); // R8
    end
  end

  for (genvar i = 0; i < N - 1; i++) begin : g_ord
    AST_OUT_ORDERED: assert property (@(posedge clk) disable iff (!rst_n) dout[i*W +: W] <= dout[(i+1)*W +: W]); // R1
  end
endmodule

// File: tb/bitonic_sorter_tb.sv
`timescale 1ns/1ps
module bitonic_sorter_tb_top;
  localparam int W   = 4;
  localparam int N   = 16;
  localparam int LAT = 10;
  localparam int NRAND = 3000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N*W-1:0]  din = '0;
  logic [N*W-1:0]  dout_p, dout_c;
  int checks = 0;
  int fails  = 0;
  logic [N*W-1:0]  hist [0:15];
  string           htag [0:15];

  always #4 clk = ~clk;

  bitonic_sorter #(.W(W), .PIPE(1'b1)) dut_i (.clk(clk), .rst_n(rst_n), .din(din), .dout(dout_p));
  bitonic_sorter #(.W(W), .PIPE(1'b0)) dut_c (.clk(clk), .rst_n(rst_n), .din(din), .dout(dout_c));

  function automatic logic [N*W-1:0] sorted_of(input logic [N*W-1:0] v);
    int cnt [0:(1<<W)-1];
    logic [N*W-1:0] r;
    int pos;
    for (int k = 0; k < (1<<W); k++) cnt[k] = 0;
    for (int k = 0; k < N; k++) cnt[v[k*W +: W]]++;
    pos = 0;
    r = '0;
    for (int val = 0; val < (1<<W); val++)
      for (int c = 0; c < cnt[val]; c++) begin
        r[pos*W +: W] = W'(val);
        pos++;
      end
    return r;
  endfunction

  task automatic check(input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic logic [N*W-1:0] pick(input int n);
    logic [N*W-1:0] v;
    v = '0;
    case (n)
      0: for (int k = 0; k < N; k++) v[k*W +: W] = W'(k);
      1: for (int k = 0; k < N; k++) v[k*W +: W] = W'(N-1-k);
      2: for (int k = 0; k < N; k++) v[k*W +: W] = 4'd9;
      3: for (int k = 0; k < N; k++) v[k*W +: W] = (k % 3 == 0) ? 4'hF : 4'h0;
      4: for (int k = 0; k < N; k++) v[k*W +: W] = (k == 0) ? 4'hF : 4'h0;
      default:
        for (int k = 0; k < N; k++)
          v[k*W +: W] = (n % 2 == 0) ? W'($urandom_range(3, 0) * 5) : W'($urandom_range(15, 0));
    endcase
    return v;
  endfunction

  function automatic string tag_of(input int n);
    case (n)
      0, 1: return "R6";
      2:    return "R7";
      3, 4: return "R8";
      default: return "R1 R2";
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [N*W-1:0] v;
    din = pick(0);
    repeat (3) @(negedge clk);
    check("R5 reset clears", dout_p, '0);
    rst_n = 1'b1;
    for (int n = 0; n < NRAND + LAT; n++) begin
      @(negedge clk);
      if (n >= LAT) check({"R3 ", htag[(n-LAT)%16]}, dout_p, hist[(n-LAT)%16]);
      v = (n < NRAND) ? pick(n) : '0;
      din = v;
      hist[n%16] = sorted_of(v);
      htag[n%16] = tag_of(n);
      #1;
      check({"R4 ", tag_of(n)}, dout_c, sorted_of(v));
      if (n == 0) check("R6 ascending unchanged", dout_c, v);
      if (n == 1) check("R6 descending reversed", dout_c, pick(0));
      if (n == 3) check("R8 max in top lane", {60'h0, dout_c[(N-1)*W +: W]}, 64'hF);
    end
    summary();
  end
endmodule